// File: doc/BRIEF.md
# Host Port Transfer Register Set

This block is the local-processor side of a 32-bit host interface port. The local processor sees a window of four words. Offset 0 holds a control word and offset 1 a status word. Offset 2 loads the transmit register and also drops the pending read requests. Offset 3 reads the receive register and loads the transmit register without touching those requests. Accesses use a two-bit address, a read strobe and a write strobe. Reads are combinational. Writes take effect on the rising clock edge.

A loaded transmit word moves on its own into a host-side receive register. The move happens on any edge where the transmit register holds a word and the host-side register is empty. The host side is a reduced port. It can read and free the host-side register, write a word into the local receive register, present two flag bits, and raise memory-access requests. A request becomes pending only when the matching access enable is set in the control word. Two interrupt request lines combine control enables with the receive-full and transmit-empty flags.

Top module: `host_xfer_regs`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0x00000002 with both host flag inputs low, `hst_full` is 0, and both interrupt lines are 0.
- R2: A write at offset 0 stores bits 5:0 and 13:8. A read at offset 0 returns those bits, and every other bit reads 0. Control bits 4:3 drive `loc_flags`.
- R3: The status word at offset 1 has this layout: bit 0 is local receive-full, bit 1 is transmit-empty, bits 4:3 are `hst_flags`, and bits 13:8 are the pending flags. Every other bit reads 0. Writes at offset 1 change no state. A read at offset 2 returns 0.
- R4: A write at offset 2 loads the transmit word and clears transmit-empty. On the same edge it clears the read pending flags, which are bits 8, 10 and 12. The write pending flags (bits 9, 11 and 13) keep their values.
- R5: A write at offset 3 loads the transmit word and clears transmit-empty, and leaves all pending flags unchanged.
- R6: On an edge where transmit-empty is 0 and `hst_full` is 0, the transmit word is copied to `hst_rdata`, `hst_full` becomes 1 and transmit-empty becomes 1.
- R7: While `hst_full` is 1, no copy takes place and `hst_rdata` holds. A cycle with `hst_rd` clears `hst_full`, and a waiting word then moves on the following edge.
- R8: A cycle with `hst_wr` stores `hst_wdata` and sets local receive-full. A local read at offset 3 returns that word and clears receive-full. If both happen in the same cycle, receive-full ends up set.
- R9: Bit i of `acc_req` sets pending flag i only when control bit 8+i is 1. Pending order is: program read, program write, X read, X write, Y read, Y write.
- R10: `irq_rx` is high exactly when control bit 0 and receive-full are both 1. `irq_tx` is high exactly when control bit 1 and transmit-empty are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_addr | input | 2 | Local register offset |
| loc_rd | input | 1 | Local read strobe |
| loc_wr | input | 1 | Local write strobe |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data, combinational |
| hst_rd | input | 1 | Host read of host-side receive register |
| hst_rdata | output | 32 | Host-side receive register |
| hst_full | output | 1 | Host-side receive register holds a word |
| hst_wr | input | 1 | Host write into local receive register |
| hst_wdata | input | 32 | Host write data |
| hst_flags | input | 2 | Host flags shown in status bits 4:3 |
| loc_flags | output | 2 | Control bits 4:3 presented to the host |
| acc_req | input | 6 | Host memory-access requests |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
Register reads are combinational, so each read is sampled during the cycle the strobe is applied, before the edge where a receive read clears its flag. A write to the transmit register clears transmit-empty on its own edge. The copy to the host side follows one edge later, so the bench samples the status word in the cycle between those two edges. It then checks `hst_full` and `hst_rdata` in the cycle after the copy. Host-side pulses last exactly one cycle. Every result is checked at the falling edge after the edge that produces it.

// File: rtl/host_xfer_regs.sv
module host_xfer_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    loc_addr,
  input  logic          loc_rd,
  input  logic          loc_wr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata,
  input  logic          hst_rd,
  output logic [DW-1:0] hst_rdata,
  output logic          hst_full,
  input  logic          hst_wr,
  input  logic [DW-1:0] hst_wdata,
  input  logic [1:0]    hst_flags,
  output logic [1:0]    loc_flags,
  input  logic [5:0]    acc_req,
  output logic          irq_rx,
  output logic          irq_tx
);
  localparam logic [5:0] RD_MASK = 6'b010101;

  logic [5:0]    ctl_lo, acc_en, pend;
  logic [DW-1:0] tx_q, rx_q, ctl_word, sts_word;
  logic          tx_empty, rx_full;

  wire wr_ctl = loc_wr && loc_addr == 2'd0;
  wire wr_txc = loc_wr && loc_addr == 2'd2;
  wire wr_tx  = loc_wr && loc_addr == 2'd3;
  wire tx_ld  = wr_txc || wr_tx;
  wire rd_rx  = loc_rd && loc_addr == 2'd3;
  wire xfer   = !tx_empty && !hst_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_lo    <= '0;
      acc_en    <= '0;
      pend      <= '0;
      tx_q      <= '0;
      tx_empty  <= 1'b1;
      rx_q      <= '0;
      rx_full   <= 1'b0;
      hst_rdata <= '0;
      hst_full  <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl_lo <= loc_wdata[5:0];
        acc_en <= loc_wdata[13:8];
      end
      pend <= (pend | (acc_req & acc_en)) & ~(wr_txc ? RD_MASK : 6'b0);
      if (tx_ld) tx_q <= loc_wdata;
      if (tx_ld)     tx_empty <= 1'b0;
      else if (xfer) tx_empty <= 1'b1;
      if (xfer) begin
        hst_rdata <= tx_q;
        hst_full  <= 1'b1;
      end else if (hst_rd) begin
        hst_full  <= 1'b0;
      end
      if (hst_wr) begin
        rx_q    <= hst_wdata;
        rx_full <= 1'b1;
      end else if (rd_rx) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl_word        = '0;
    ctl_word[5:0]   = ctl_lo;
    ctl_word[13:8]  = acc_en;
    sts_word        = '0;
    sts_word[0]     = rx_full;
    sts_word[1]     = tx_empty;
    sts_word[4:3]   = hst_flags;
    sts_word[13:8]  = pend;
  end

  always_comb begin
    loc_rdata = '0;
    if (loc_rd) begin
      case (loc_addr)
        2'd0:    loc_rdata = ctl_word;
        2'd1:    loc_rdata = sts_word;
        2'd3:    loc_rdata = rx_q;
        default: loc_rdata = '0;
      endcase
    end
  end

  assign loc_flags = ctl_lo[4:3];
  assign irq_rx    = ctl_lo[0] & rx_full;
  assign irq_tx    = ctl_lo[1] & tx_empty;
endmodule

module host_xfer_regs_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    loc_addr,
  input logic          loc_wr,
  input logic          hst_rd,
  input logic          hst_wr,
  input logic [DW-1:0] hst_rdata,
  input logic          hst_full,
  input logic          tx_empty,
  input logic          rx_full,
  input logic [5:0]    pend,
  input logic [5:0]    acc_en
);
  AST_TX_LOAD_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr && loc_addr[1]) |=> !tx_empty); // R4
  AST_TXC_DROPS_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr && loc_addr == 2'd2) |=> (pend & 6'b010101) == 6'b0); // R4
  AST_XFER_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && !hst_full) |=> (hst_full && tx_empty) || (loc_wr && $past(loc_addr[1]))); // R6
  AST_FULL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_full && !hst_rd) |=> $stable(hst_rdata) && hst_full); // R7
  AST_HOST_WR_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    hst_wr |=> rx_full); // R8
  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(acc_en)) == 6'b0)); // R9
endmodule

bind host_xfer_regs host_xfer_regs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .loc_addr(loc_addr), .loc_wr(loc_wr),
  .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_rdata(hst_rdata), .hst_full(hst_full),
  .tx_empty(tx_empty), .rx_full(rx_full), .pend(pend), .acc_en(acc_en)
);

// File: tb/sim_host_xfer_regs.sv
module sim_host_xfer_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  loc_addr = '0;
  logic        loc_rd = 1'b0, loc_wr = 1'b0;
  logic [31:0] loc_wdata = '0, loc_rdata;
  logic        hst_rd = 1'b0, hst_wr = 1'b0;
  logic [31:0] hst_rdata, hst_wdata = '0;
  logic        hst_full;
  logic [1:0]  hst_flags = '0, loc_flags;
  logic [5:0]  acc_req = '0;
  logic        irq_rx, irq_tx;

  int nvec = 0, nfail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  host_xfer_regs u0 (
    .clk(clk), .rst_n(rst_n), .loc_addr(loc_addr), .loc_rd(loc_rd), .loc_wr(loc_wr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .hst_rd(hst_rd), .hst_rdata(hst_rdata),
    .hst_full(hst_full), .hst_wr(hst_wr), .hst_wdata(hst_wdata), .hst_flags(hst_flags),
    .loc_flags(loc_flags), .acc_req(acc_req), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  localparam int NV = 6;
  localparam logic [31:0] VW [NV] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_2A15,
                                      32'hFFFF_C0C0, 32'h0000_1524, 32'h0000_0000};
  localparam logic [31:0] VE [NV] = '{32'h0000_3F3F, 32'h0000_0000, 32'h0000_2A15,
                                      32'h0000_0000, 32'h0000_1524, 32'h0000_0000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lwrite(input logic [1:0] a, input logic [31:0] d);
    loc_addr = a; loc_wdata = d; loc_wr = 1'b1;
    @(negedge clk);
    loc_wr = 1'b0;
  endtask

  task automatic lread(input logic [1:0] a, output logic [31:0] d);
    loc_addr = a; loc_rd = 1'b1;
    #1 d = loc_rdata;
    @(negedge clk);
    loc_rd = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic hread();
    hst_rd = 1'b1;
    @(negedge clk);
    hst_rd = 1'b0;
  endtask

  task automatic hwrite(input logic [31:0] d);
    hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic req(input logic [5:0] r);
    acc_req = r;
    @(negedge clk);
    acc_req = '0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle();

    lread(0, d); chk("R1 ctl", d, 32'h0);
    lread(1, d); chk("R1 status", d, 32'h2);
    chk("R1 hst_full", {31'b0, hst_full}, 32'h0);
    chk("R1 irq", {30'b0, irq_rx, irq_tx}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      lwrite(0, VW[i]);
      lread(0, d);
      chk("R2 ctl readback", d, VE[i]);
      chk("R2 loc_flags", {30'b0, loc_flags}, {30'b0, VE[i][4:3]});
    end

    hst_flags = 2'b10;
    lread(1, d); chk("R3 host flags", d, 32'h12);
    hst_flags = 2'b00;
    lwrite(1, 32'hFFFF_FFFF);
    lread(1, d); chk("R3 status write ignored", d, 32'h2);
    lread(0, d); chk("R3 ctl untouched", d, 32'h0);
    lread(2, d); chk("R3 offset2 reads zero", d, 32'h0);

    req(6'h3F);
    lread(1, d); chk("R9 req without enable", d, 32'h2);
    lwrite(0, 32'h0000_1400);
    req(6'h3F);
    lread(1, d); chk("R9 only enabled bits pend", d, 32'h1402);
    lwrite(0, 32'h0000_3F00);
    req(6'h3F);
    lread(1, d); chk("R9 all pend", d, 32'h3F02);

    lwrite(3, 32'hA5A5_0001);
    lread(1, d); chk("R5 plain write keeps pend", d, 32'h3F00);
    chk("R6 moved", hst_rdata, 32'hA5A5_0001);
    hread();
    lwrite(2, 32'hC3C3_0002);
    lread(1, d); chk("R4 clear-write drops reads", d, 32'h2A00);
    chk("R6 moved after clear-write", hst_rdata, 32'hC3C3_0002);
    hread();

    lwrite(0, 32'h0);
    lwrite(3, 32'h1111_2222);
    chk("R6 not yet full", {31'b0, hst_full}, 32'h0);
    lread(1, d); chk("R6 empty cleared", d, 32'h2A00);
    chk("R6 full set", {31'b0, hst_full}, 32'h1);
    chk("R6 data", hst_rdata, 32'h1111_2222);
    lread(1, d); chk("R6 empty set", d, 32'h2A02);

    lwrite(3, 32'h3333_4444);
    idle(); idle();
    chk("R7 data held", hst_rdata, 32'h1111_2222);
    lread(1, d); chk("R7 word waits", d, 32'h2A00);
    hread();
    chk("R7 full cleared", {31'b0, hst_full}, 32'h0);
    idle();
    chk("R7 waiting word moved", hst_rdata, 32'h3333_4444);
    chk("R7 full again", {31'b0, hst_full}, 32'h1);
    hread();

    hwrite(32'h5555_6666);
    lread(1, d); chk("R8 rx full", d, 32'h2A03);
    lread(3, d); chk("R8 rx data", d, 32'h5555_6666);
    lread(1, d); chk("R8 rx cleared by read", d, 32'h2A02);
    hst_wdata = 32'h7777_8888; hst_wr = 1'b1;
    loc_addr = 2'd3; loc_rd = 1'b1;
    @(negedge clk);
    hst_wr = 1'b0; loc_rd = 1'b0;
    lread(1, d); chk("R8 set wins over clear", d, 32'h2A03);
    lread(3, d); chk("R8 new data", d, 32'h7777_8888);

    lwrite(0, 32'h3);
    chk("R10 tx irq on empty", {30'b0, irq_rx, irq_tx}, 32'h1);
    hwrite(32'h9);
    chk("R10 both irqs", {30'b0, irq_rx, irq_tx}, 32'h3);
    lwrite(0, 32'h1);
    chk("R10 rx only", {30'b0, irq_rx, irq_tx}, 32'h2);
    lwrite(0, 32'h2);
    chk("R10 rx masked", {30'b0, irq_rx, irq_tx}, 32'h1);
    lwrite(3, 32'hABCD);
    chk("R10 tx low while loaded", {30'b0, irq_rx, irq_tx}, 32'h0);
    idle();
    chk("R10 tx high after move", {30'b0, irq_rx, irq_tx}, 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nvec++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule